// File: doc/BRIEF.md
# Video DRAM Cycle-Type Decoder

This block models, in a single clock domain, the control decode of a multiport video DRAM. It watches the row strobe, the two byte column strobes, the transfer-gate, write-enable and special-function pins, and the address bus. A falling row strobe starts a cycle. If either column strobe is already low at that point, the cycle is a refresh variant and is classified at once. Otherwise the block notes the write-enable and special-function levels. It then waits for the column strobe to fall, and the special-function level at that moment tells a normal write from a block write, or the write-mask register from the color register.

Each classified cycle produces a one-clock pulse on one bit of a one-hot type vector. A pin combination that is reserved produces a pulse on a separate flag instead. Two sticky modes are kept: persistent write-per-bit and stop-point, together with a 4-bit stop-point code. Because these modes are set and cleared by particular cycles, a masked write is classified by the pins and also by the mode history.

Top module: `vdram_cycle_decoder`

## Requirements
- R1: The column strobe counts as low when `casl_n` or `casu_n` (or both) is low; a fall is the change from both high to at least one low.
- R2: A classified cycle gives a pulse exactly one clock long on one bit of `cyc_type_o`, registered at the clock edge where the deciding strobe fall is first sampled. Bit positions: 0 stop-point refresh, 1 option-reset refresh, 2 plain refresh, 3 write, 4 masked write (nonpersistent), 5 masked write (persistent), 6 block write, 7 masked block write (nonpersistent), 8 masked block write (persistent), 9 write-mask load, 10 color load.
- R3: With the column strobe low at row fall, `we_n`=0/`dsf`=1 gives bit 0, `we_n`=1/`dsf`=0 gives bit 1, and `we_n`=1/`dsf`=1 gives bit 2, whatever `trg_n` is.
- R4: Column strobe low, `trg_n`=0, `we_n`=0 and `dsf`=0 at row fall pulses `reserved_o`, with no bit of `cyc_type_o` and no change to the modes or the code.
- R5: The stop-point refresh loads `stop_code_o` from `addr_i[7:4]` and sets `stop_mode_o`. Address bits 0 to 3 and bit 8 have no effect.
- R6: The option-reset refresh clears `pwpb_mode_o` and `stop_mode_o` and keeps `stop_code_o`. The plain refresh changes none of the three.
- R7: With column strobe high, `trg_n`=1, `we_n`=1 and `dsf`=1 at row fall, the cycle is a register load, decided at column fall: `dsf`=0 gives bit 9 and `dsf`=1 gives bit 10.
- R8: A write-mask load sets `pwpb_mode_o`. Only the option-reset refresh clears it.
- R9: With column strobe high, `trg_n`=1 and `dsf`=0 at row fall, nothing is reported at row fall. At column fall, `we_n` from row fall selects masked (0) or plain (1), and `dsf` at column fall selects block write (1) or write (0).
- R10: A masked write or masked block write is reported as persistent (bit 5 or 8) when `pwpb_mode_o` is set, and as nonpersistent (bit 4 or 7) otherwise.
- R11: These report nothing and change no state: row fall with the column strobe high and `trg_n`=0, or with `we_n`=0/`dsf`=1; CAS-before-RAS with `trg_n`=1, `we_n`=0, `dsf`=0; a row strobe that rises before the column strobe falls; and a column fall while the row strobe is high.
- R12: After reset, `cyc_type_o`, `reserved_o`, both mode flags and `stop_code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower byte column strobe, active low |
| casu_n | input | 1 | Upper byte column strobe, active low |
| trg_n | input | 1 | Transfer-gate, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function select |
| addr_i | input | ADDR_W (9) | Multiplexed address |
| cyc_type_o | output | 11 | One-hot cycle-type pulse |
| reserved_o | output | 1 | Reserved-combination pulse |
| pwpb_mode_o | output | 1 | Persistent write-per-bit mode |
| stop_mode_o | output | 1 | Stop-point mode |
| stop_code_o | output | STOP_W (4) | Stored stop-point code |

## Verification
The hardest case to reach from the ports is a masked write whose persistent or nonpersistent label depends on a write-mask load made several cycles before. Correct handling also requires that no plain refresh, reserved cycle or aborted cycle in between has disturbed that mode. Random sequences of whole cycles are generated, with both column strobes picked at random, so that loads, option-reset refreshes and masked writes interleave in many orders. Directed sequences first place a stop-point refresh with junk in the ignored address bits, and then a reserved cycle and an aborted cycle, and check that the modes survive.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

    localparam int NUM_CYC = 11;

    typedef enum logic [3:0] {
        CY_REF_STOP  = 4'd0,
        CY_REF_RESET = 4'd1,
        CY_REF_KEEP  = 4'd2,
        CY_WR        = 4'd3,
        CY_WRM_NP    = 4'd4,
        CY_WRM_P     = 4'd5,
        CY_BW        = 4'd6,
        CY_BWM_NP    = 4'd7,
        CY_BWM_P     = 4'd8,
        CY_LD_WMASK  = 4'd9,
        CY_LD_COLOR  = 4'd10
    } cyc_e;

    typedef enum logic [1:0] {
        ROW_IGNORE   = 2'd0,
        ROW_REFRESH  = 2'd1,
        ROW_RESERVED = 2'd2,
        ROW_WAIT     = 2'd3
    } row_act_e;

    typedef enum logic [1:0] {
        PEND_WR   = 2'd0,
        PEND_WRM  = 2'd1,
        PEND_LOAD = 2'd2
    } pend_e;

    typedef enum logic {
        PH_IDLE     = 1'b0,
        PH_WAIT_COL = 1'b1
    } phase_e;

    function automatic cyc_e col_classify(pend_e pend, logic dsf_col, logic persist);
        cyc_e t;
        unique case (pend)
            PEND_WR:  t = dsf_col ? CY_BW : CY_WR;
            PEND_WRM: begin
                if (dsf_col) t = persist ? CY_BWM_P : CY_BWM_NP;
                else         t = persist ? CY_WRM_P : CY_WRM_NP;
            end
            default:  t = dsf_col ? CY_LD_COLOR : CY_LD_WMASK;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/vdc_edge_detect.sv
module vdc_edge_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_fall
        assign fall[i] = prev_q[i] & ~lvl_n[i];
    end
endmodule

// File: rtl/vdc_row_classify.sv
module vdc_row_classify
    import vdc_pkg::*;
(
    input  logic     cas_low,
    input  logic     trg_n,
    input  logic     we_n,
    input  logic     dsf,
    output row_act_e act,
    output cyc_e     ref_type,
    output pend_e    pend
);
    always_comb begin
        act      = ROW_IGNORE;
        ref_type = CY_REF_KEEP;
        pend     = PEND_WR;
        if (cas_low) begin
            unique case ({we_n, dsf})
                2'b00: act = trg_n ? ROW_IGNORE : ROW_RESERVED;
                2'b01: begin act = ROW_REFRESH; ref_type = CY_REF_STOP;  end
                2'b10: begin act = ROW_REFRESH; ref_type = CY_REF_RESET; end
                default: begin act = ROW_REFRESH; ref_type = CY_REF_KEEP; end
            endcase
        end else if (trg_n) begin
            unique case ({we_n, dsf})
                2'b00: begin act = ROW_WAIT; pend = PEND_WRM;  end
                2'b10: begin act = ROW_WAIT; pend = PEND_WR;   end
                2'b11: begin act = ROW_WAIT; pend = PEND_LOAD; end
                default: act = ROW_IGNORE;
            endcase
        end
    end
endmodule

// File: rtl/vdram_cycle_decoder.sv
module vdram_cycle_decoder
    import vdc_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int STOP_W  = 4,
    parameter int STOP_LSB = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                casl_n,
    input  logic                casu_n,
    input  logic                trg_n,
    input  logic                we_n,
    input  logic                dsf,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [NUM_CYC-1:0]  cyc_type_o,
    output logic                reserved_o,
    output logic                pwpb_mode_o,
    output logic                stop_mode_o,
    output logic [STOP_W-1:0]   stop_code_o
);
    localparam logic [ADDR_W-1:0] STOP_MASK =
        ADDR_W'(((1 << STOP_W) - 1) << STOP_LSB);

    typedef struct packed {
        phase_e               ph;
        pend_e                pend;
        logic [NUM_CYC-1:0]   cyc;
        logic                 rsv;
        logic                 pwpb;
        logic                 stp;
        logic [STOP_W-1:0]    code;
    } st_t;

    st_t st_d, st_q;

    logic               cas_comb_n;
    logic [1:0]         falls;
    logic               row_fall, col_fall;
    row_act_e           row_act;
    cyc_e               ref_type;
    pend_e              row_pend;
    cyc_e               col_type;
    logic [ADDR_W-1:0]  addr_unused_bits;

    assign cas_comb_n       = casl_n & casu_n;
    assign addr_unused_bits = addr_i & ~STOP_MASK;

    vdc_edge_detect #(.N(2)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n ({cas_comb_n, ras_n}),
        .fall  (falls)
    );
    assign row_fall = falls[0];
    assign col_fall = falls[1] & ~ras_n;

    vdc_row_classify row_i (
        .cas_low  (~cas_comb_n),
        .trg_n    (trg_n),
        .we_n     (we_n),
        .dsf      (dsf),
        .act      (row_act),
        .ref_type (ref_type),
        .pend     (row_pend)
    );

    assign col_type = col_classify(st_q.pend, dsf, st_q.pwpb);

    always_comb begin
        st_d     = st_q;
        st_d.cyc = '0;
        st_d.rsv = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (row_fall) begin
                    unique case (row_act)
                        ROW_RESERVED: st_d.rsv = 1'b1;
                        ROW_REFRESH: begin
                            st_d.cyc[ref_type] = 1'b1;
                            if (ref_type == CY_REF_STOP) begin
                                st_d.stp  = 1'b1;
                                st_d.code = addr_i[STOP_LSB +: STOP_W];
                            end else if (ref_type == CY_REF_RESET) begin
                                st_d.stp  = 1'b0;
                                st_d.pwpb = 1'b0;
                            end
                        end
                        ROW_WAIT: begin
                            st_d.ph   = PH_WAIT_COL;
                            st_d.pend = row_pend;
                        end
                        default: ;
                    endcase
                end
            end
            default: begin
                if (ras_n) begin
                    st_d.ph = PH_IDLE;
                end else if (col_fall) begin
                    st_d.ph            = PH_IDLE;
                    st_d.cyc[col_type] = 1'b1;
                    if (col_type == CY_LD_WMASK) st_d.pwpb = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, pend: PEND_WR, cyc: '0, rsv: 1'b0,
                      pwpb: 1'b0, stp: 1'b0, code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_type_o  = st_q.cyc;
    assign reserved_o  = st_q.rsv;
    assign pwpb_mode_o = st_q.pwpb;
    assign stop_mode_o = st_q.stp;
    assign stop_code_o = st_q.code;
endmodule

// File: rtl/vdc_checker.sv
module vdc_checker
    import vdc_pkg::*;
#(
    parameter int STOP_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CYC-1:0] cyc_type,
    input logic               rsv,
    input logic               pwpb,
    input logic               stp,
    input logic [STOP_W-1:0]  code
);
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cyc_type));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type != '0) |=> (cyc_type == '0));

    a_r4_reserved_alone: assert property (@(posedge clk) disable iff (!rst_n)
        rsv |-> (cyc_type == '0));

    a_r4_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        rsv |-> ($stable(pwpb) && $stable(stp) && $stable(code)));

    a_r5_stop_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_type[CY_REF_STOP] |-> stp);

    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_type[CY_REF_RESET] |-> (!pwpb && !stp && $stable(code)));

    a_r6_keep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_type[CY_REF_KEEP] |-> ($stable(pwpb) && $stable(stp) && $stable(code)));

    a_r8_pwpb_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwpb) |-> cyc_type[CY_LD_WMASK]);

    a_r8_pwpb_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwpb) |-> cyc_type[CY_REF_RESET]);

    a_r10_persist: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type[CY_WRM_P] || cyc_type[CY_BWM_P]) |-> pwpb);

    a_r10_nonpersist: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type[CY_WRM_NP] || cyc_type[CY_BWM_NP]) |-> !pwpb);
endmodule

bind vdram_cycle_decoder vdc_checker #(.STOP_W(STOP_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_type (cyc_type_o),
    .rsv      (reserved_o),
    .pwpb     (pwpb_mode_o),
    .stp      (stop_mode_o),
    .code     (stop_code_o)
);

// File: tb/vdram_cycle_decoder_tb.sv
module vdram_cycle_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCYC = 11;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, casl_n = 1'b1, casu_n = 1'b1;
    logic trg_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
    logic [8:0] addr = '0;
    logic [NCYC-1:0] cyc_type;
    logic reserved, pwpb, stp;
    logic [3:0] code;

    int total = 0;
    int bad = 0;
    bit m_pwpb = 0, m_stp = 0;
    logic [3:0] m_code = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vdram_cycle_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .casu_n(casu_n),
        .trg_n(trg_n), .we_n(we_n), .dsf(dsf), .addr_i(addr),
        .cyc_type_o(cyc_type), .reserved_o(reserved), .pwpb_mode_o(pwpb),
        .stop_mode_o(stp), .stop_code_o(code)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic chk_all(string tag, logic [NCYC-1:0] ev, bit er);
        chk({tag, " type"}, 32'(cyc_type), 32'(ev));
        chk({tag, " reserved"}, 32'(reserved), 32'(er));
        chk({tag, " pwpb"}, 32'(pwpb), 32'(m_pwpb));
        chk({tag, " stop"}, 32'(stp), 32'(m_stp));
        chk({tag, " code"}, 32'(code), 32'(m_code));
    endtask

    function automatic logic [NCYC-1:0] bitv(int i);
        return NCYC'(1) << i;
    endfunction

    task automatic cas_low(int sel);
        casl_n = (sel == 1) ? 1'b1 : 1'b0;
        casu_n = (sel == 0) ? 1'b1 : 1'b0;
    endtask

    // R1/R3/R4/R5/R6/R11: CAS-before-RAS cycle
    task automatic run_cbr(bit w, bit f, bit t, logic [8:0] a, int sel, string tag);
        logic [NCYC-1:0] ev;
        bit er;
        @(negedge clk);
        ras_n = 1'b1; cas_low(sel); we_n = w; dsf = f; trg_n = t; addr = a;
        @(negedge clk);
        ras_n = 1'b0;
        @(negedge clk);
        ev = '0; er = 0;
        case ({w, f})
            2'b00: er = !t;
            2'b01: begin ev = bitv(0); m_stp = 1; m_code = a[7:4]; end
            2'b10: begin ev = bitv(1); m_stp = 0; m_pwpb = 0; end
            default: ev = bitv(2);
        endcase
        chk_all(tag, ev, er);
        ras_n = 1'b1; casl_n = 1'b1; casu_n = 1'b1;
        @(negedge clk);
        chk({tag, " R2 pulse end"}, 32'(cyc_type), 32'(0));
    endtask

    // R7/R9/R10/R11: row fall with column strobe high
    task automatic run_rc(bit t, bit w, bit fr, bit fc, logic [8:0] a, int sel,
                          bit abort, string tag);
        logic [NCYC-1:0] ev;
        int idx;
        @(negedge clk);
        ras_n = 1'b1; casl_n = 1'b1; casu_n = 1'b1;
        trg_n = t; we_n = w; dsf = fr; addr = a;
        @(negedge clk);
        ras_n = 1'b0;
        @(negedge clk);
        chk_all({tag, " R9 row"}, '0, 0);
        dsf = fc;
        if (abort) ras_n = 1'b1;
        cas_low(sel);
        @(negedge clk);
        ev = '0;
        if (!abort && t && !(!w && fr)) begin
            if (!fr) begin
                if (w) idx = fc ? 6 : 3;
                else   idx = fc ? (m_pwpb ? 8 : 7) : (m_pwpb ? 5 : 4);
            end else begin
                idx = fc ? 10 : 9;
                if (!fc) m_pwpb = 1;
            end
            ev = bitv(idx);
        end
        chk_all(tag, ev, 0);
        ras_n = 1'b1; casl_n = 1'b1; casu_n = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk_all("R12 reset", '0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R12 after release", '0, 0);

        run_cbr(0, 1, 1, 9'h1_5F, 0, "R5 stop set junk bits");       // code 5
        run_cbr(0, 0, 0, 9'h0_A0, 2, "R4 reserved keeps code");
        run_cbr(0, 0, 1, 9'h0_30, 1, "R11 cbr trg high ignored");
        run_rc(1, 1, 1, 0, 9'h000, 0, 0, "R7 R8 wmask load");
        run_rc(1, 0, 0, 0, 9'h000, 1, 0, "R10 masked persistent");
        run_rc(1, 0, 0, 1, 9'h000, 2, 0, "R10 block masked persistent");
        run_cbr(1, 1, 0, 9'h0_F0, 1, "R6 keep refresh");
        run_rc(1, 0, 0, 0, 9'h000, 0, 1, "R11 abort");
        run_rc(0, 1, 0, 1, 9'h000, 0, 0, "R11 transfer ignored");
        run_rc(1, 0, 1, 0, 9'h000, 0, 0, "R11 we low dsf high ignored");
        run_rc(1, 1, 1, 1, 9'h000, 2, 0, "R7 color load");
        run_cbr(1, 0, 1, 9'h0_00, 2, "R6 R8 option reset");
        run_rc(1, 0, 0, 0, 9'h000, 0, 0, "R10 masked nonpersistent");
        run_rc(1, 0, 0, 1, 9'h000, 1, 0, "R10 block masked nonpersistent");
        run_rc(1, 1, 0, 0, 9'h000, 0, 0, "R9 plain write");
        run_rc(1, 1, 0, 1, 9'h000, 1, 0, "R9 block write");

        // column fall with row strobe high does nothing (R11)
        @(negedge clk);
        cas_low(0);
        @(negedge clk);
        chk_all("R11 column fall alone", '0, 0);
        casl_n = 1'b1; casu_n = 1'b1;

        for (int n = 0; n < 600; n++) begin
            int kind;
            bit t, w, fr, fc;
            logic [8:0] a;
            int sel;
            kind = int'($urandom_range(0, 9));
            t  = ($urandom_range(0, 4) != 0);
            w  = 1'($urandom);
            fr = 1'($urandom);
            fc = 1'($urandom);
            a  = 9'($urandom);
            sel = int'($urandom_range(0, 2));
            if (kind < 4)       run_cbr(w, fr, t, a, sel, "R3 rand cbr");
            else if (kind == 9) run_rc(t, w, fr, fc, a, sel, 1, "R11 rand abort");
            else                run_rc(t, w, fr, fc, a, sel, 0, "R9 rand write/load");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule